// File: doc/BRIEF.md
# Character-Cell Rectangle Engine

This block performs rectangular operations on a text buffer in which every character cell is a 16-bit word. The low byte of the word holds a glyph index. The high byte holds a colour attribute. A controller places the operation parameters on the inputs and pulses `start`. The engine then walks the rectangle cell by cell over a simple synchronous memory port. It holds `busy` high while it works and pulses `done` when it finishes.

There are three operations:

- **Copy** moves whole cells from one rectangle to another. It chooses its scan direction from the two corners, so overlapping source and destination rectangles come out intact.
- **Fill** writes the same glyph and attribute into every cell.
- **Stream** writes glyph indices, taken from an external source one per cell, together with a fixed attribute.

The attribute byte is built from the low four bits of the background and foreground colour inputs. The cell geometry is configurable. The byte distance between neighbouring cells is a power of two times two. The byte distance between rows follows from the width of the virtual line in pixels.

Top module: `text_cell_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd`, `mem_wr` and `idx_pop` are all low. A memory strobe is only ever asserted while `busy` is high.
- R2: Cell (c, r) lies at byte address `base_addr + c*S + r*S*(line_pixels/8)`, where S = 2 << `stride_exp`. Every access is one 16-bit word at that even address. The glyph occupies bits 7:0 and the attribute occupies bits 15:8.
- R3: Fill (`opcode` = 1) writes glyph `fill_glyph` and attribute `{bg_color[3:0], fg_color[3:0]}` into every cell of the rectangle. The rectangle is `rect_w` by `rect_h` cells with its top-left cell at (`dst_col`, `dst_row`). No other word changes. Fill takes one cycle per cell.
- R4: Copy (`opcode` = 0) leaves every destination cell holding what the matching source cell held before the operation, even when the rectangles overlap. The scan runs forward from the top-left cell when `src_row` > `dst_row`, or when the rows are equal and `src_col` > `dst_col`. Otherwise it runs backward from the bottom-right cell.
- R5: Copy issues exactly one read of a source cell, and then in the next cycle one write of the destination cell, per cell. That gives `rect_w*rect_h` reads, the same number of writes, and 2*`rect_w*rect_h` busy cycles.
- R6: Stream (`opcode` = 2) writes cells in row-major order. Each cell gets glyph `idx_data` and the attribute from R3. `idx_pop` is high for exactly the cycle in which the current `idx_data` is written. The operation stops after `stream_len` glyphs or when the rectangle is full, whichever comes first.
- R7: A zero `rect_w`, zero `rect_h` or (for stream) zero `stream_len` raises `done` in the cycle after `start`. `busy` stays low and no memory access occurs.
- R8: `done` is a single-cycle pulse in the cycle after the last access. `done` and `busy` are never high together.
- R9: A `start` pulse while `busy` is high is ignored and leaves memory untouched. A `start` in the cycle where `done` is high is accepted.
- R10: `opcode` = 3 performs no access and completes like R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| opcode | input | 2 | 0 copy, 1 fill, 2 stream, 3 no-op |
| base_addr | input | ADDR_W | Byte address of cell (0,0) |
| stride_exp | input | SHIFT_W | Cell stride exponent |
| line_pixels | input | LINE_W | Virtual line width in pixels |
| src_col | input | COORD_W | Copy source left column |
| src_row | input | COORD_W | Copy source top row |
| dst_col | input | COORD_W | Destination left column |
| dst_row | input | COORD_W | Destination top row |
| rect_w | input | COORD_W | Rectangle width in cells |
| rect_h | input | COORD_W | Rectangle height in cells |
| fill_glyph | input | 8 | Glyph for fill |
| fg_color | input | 8 | Foreground colour (low nibble used) |
| bg_color | input | 8 | Background colour (low nibble used) |
| stream_len | input | LEN_W | Number of glyphs in a stream |
| idx_data | input | 8 | Current stream glyph |
| idx_pop | output | 1 | Current stream glyph consumed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| mem_addr | output | ADDR_W | Byte address of the word access |
| mem_wdata | output | 16 | Write data |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |

## Verification
Two functions can meet in the same cycle: acceptance of a new `start` and the completion of the previous operation. Also, a `start` can arrive in the middle of a running walk. The bench provokes the first case by raising `start` in the very cycle it sees `done`, and it expects both operations in memory. It provokes the second by pulsing `start` with a different opcode partway through a long fill, and it expects the memory image to show the fill alone with exactly one `done`. Overlapping copies in all four corner relations are compared against a bench model that copies cell by cell in the required order.

// File: rtl/text_cell_pkg.sv
// Shared types of the character-cell engine: operation codes and FSM states.
package text_cell_pkg;
    typedef enum logic [1:0] {
        OP_COPY   = 2'd0,
        OP_FILL   = 2'd1,
        OP_STREAM = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FILL,
        ST_STREAM
    } st_e;
endpackage

// File: rtl/cell_addr.sv
// Maps a cell coordinate to its byte address.
// Assumes the caller keeps coordinates within the buffer; the result wraps at ADDR_W.
module cell_addr #(
    parameter int ADDR_W  = 20,
    parameter int COORD_W = 8,
    parameter int SHIFT_W = 2,
    parameter int CPL_W   = 9
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CPL_W-1:0]   cells_per_line,
    input  logic [COORD_W:0]   x,
    input  logic [COORD_W:0]   y,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] cell_lin;

    // linear cell number scaled by the cell stride (2 << shift)
    always_comb begin
        cell_lin = ADDR_W'(x) + ADDR_W'(y) * ADDR_W'(cells_per_line);
        addr     = base + (cell_lin << (int'(shift) + 1));
    end
endmodule

// File: rtl/rect_walker.sv
// Row-major offset counter over a w-by-h rectangle.
// Assumes w and h are non-zero and stable between load and the last step.
module rect_walker #(
    parameter int COORD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    output logic [COORD_W-1:0] col_i,
    output logic [COORD_W-1:0] row_j,
    output logic               last
);
    logic end_col;

    // flags the final column and the final cell
    always_comb begin
        end_col = (col_i == w - COORD_W'(1));
        last    = end_col && (row_j == h - COORD_W'(1));
    end

    // advances the column, wrapping into the next row
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            col_i <= '0;
            row_j <= '0;
        end else if (step) begin
            if (end_col) begin
                col_i <= '0;
                row_j <= row_j + COORD_W'(1);
            end else begin
                col_i <= col_i + COORD_W'(1);
            end
        end
    end
endmodule

// File: rtl/text_cell_engine.sv
// Rectangle copy / fill / stream engine for a text buffer of 16-bit cells
// (glyph in bits 7:0, attribute in bits 15:8).
// Assumes: mem_rdata is valid the cycle after mem_rd; rectangles lie inside
// the buffer; operation inputs only matter in the cycle start is accepted.
module text_cell_engine
    import text_cell_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int COORD_W = 8,
    parameter int SHIFT_W = 2,
    parameter int LINE_W  = 12,
    parameter int LEN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         opcode,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [SHIFT_W-1:0] stride_exp,
    input  logic [LINE_W-1:0]  line_pixels,
    input  logic [COORD_W-1:0] src_col,
    input  logic [COORD_W-1:0] src_row,
    input  logic [COORD_W-1:0] dst_col,
    input  logic [COORD_W-1:0] dst_row,
    input  logic [COORD_W-1:0] rect_w,
    input  logic [COORD_W-1:0] rect_h,
    input  logic [7:0]         fill_glyph,
    input  logic [7:0]         fg_color,
    input  logic [7:0]         bg_color,
    input  logic [LEN_W-1:0]   stream_len,
    input  logic [7:0]         idx_data,
    output logic               idx_pop,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [15:0]        mem_wdata,
    output logic               mem_rd,
    output logic               mem_wr,
    input  logic [15:0]        mem_rdata
);
    localparam int CPL_W = LINE_W - 3;

    st_e                st;
    op_e                op_in;
    logic [ADDR_W-1:0]  base_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [CPL_W-1:0]   cpl_q;
    logic [COORD_W-1:0] sc_q, sr_q, dc_q, dr_q, w_q, h_q;
    logic [7:0]         glyph_q, attr_q;
    logic [LEN_W-1:0]   len_q, used_q;
    logic               back_q;
    logic               no_work, fwd_in, accept, step, last;
    logic [COORD_W-1:0] col_i, row_j, ox, oy;
    logic [COORD_W:0]   sx, sy, dx, dy;
    logic [ADDR_W-1:0]  src_a, dst_a;

    // decodes the request and the copy scan direction
    always_comb begin
        op_in   = op_e'(opcode);
        no_work = (rect_w == '0) || (rect_h == '0) || (op_in == OP_NONE)
                  || ((op_in == OP_STREAM) && (stream_len == '0));
        fwd_in  = (src_row > dst_row) || ((src_row == dst_row) && (src_col > dst_col));
        accept  = (st == ST_IDLE) && start;
        step    = (st == ST_WRITE) || (st == ST_FILL) || (st == ST_STREAM);
    end

    rect_walker #(.COORD_W(COORD_W)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (step),
        .w     (w_q),
        .h     (h_q),
        .col_i (col_i),
        .row_j (row_j),
        .last  (last)
    );

    // mirrors the walk offsets for a backward scan and forms cell coordinates
    always_comb begin
        ox = back_q ? (w_q - COORD_W'(1) - col_i) : col_i;
        oy = back_q ? (h_q - COORD_W'(1) - row_j) : row_j;
        sx = {1'b0, sc_q} + {1'b0, ox};
        sy = {1'b0, sr_q} + {1'b0, oy};
        dx = {1'b0, dc_q} + {1'b0, ox};
        dy = {1'b0, dr_q} + {1'b0, oy};
    end

    cell_addr #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .SHIFT_W(SHIFT_W), .CPL_W(CPL_W)) u_src_a (
        .base(base_q), .shift(shift_q), .cells_per_line(cpl_q), .x(sx), .y(sy), .addr(src_a)
    );
    cell_addr #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .SHIFT_W(SHIFT_W), .CPL_W(CPL_W)) u_dst_a (
        .base(base_q), .shift(shift_q), .cells_per_line(cpl_q), .x(dx), .y(dy), .addr(dst_a)
    );

    // drives the memory port and stream handshake from the state
    always_comb begin
        busy      = (st != ST_IDLE);
        mem_rd    = (st == ST_READ);
        mem_wr    = step;
        idx_pop   = (st == ST_STREAM);
        mem_addr  = (st == ST_READ) ? src_a : dst_a;
        mem_wdata = (st == ST_WRITE)  ? mem_rdata :
                    (st == ST_STREAM) ? {attr_q, idx_data} : {attr_q, glyph_q};
    end

    // latches the operation when it is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0; shift_q <= '0; cpl_q <= '0;
            sc_q <= '0; sr_q <= '0; dc_q <= '0; dr_q <= '0;
            w_q <= '0; h_q <= '0; glyph_q <= '0; attr_q <= '0;
            len_q <= '0; back_q <= 1'b0;
        end else if (accept) begin
            base_q  <= base_addr;
            shift_q <= stride_exp;
            cpl_q   <= line_pixels[LINE_W-1:3];
            sc_q    <= src_col;
            sr_q    <= src_row;
            dc_q    <= dst_col;
            dr_q    <= dst_row;
            w_q     <= rect_w;
            h_q     <= rect_h;
            glyph_q <= fill_glyph;
            attr_q  <= {bg_color[3:0], fg_color[3:0]};
            len_q   <= stream_len;
            back_q  <= (op_in == OP_COPY) && !fwd_in;
        end
    end

    // sequences the operation and pulses done after the last access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            done   <= 1'b0;
            used_q <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    used_q <= '0;
                    if (no_work)                  done <= 1'b1;
                    else if (op_in == OP_COPY)    st   <= ST_READ;
                    else if (op_in == OP_FILL)    st   <= ST_FILL;
                    else                          st   <= ST_STREAM;
                end
                ST_READ:  st <= ST_WRITE;
                ST_WRITE: begin
                    st <= last ? ST_IDLE : ST_READ;
                    done <= last;
                end
                ST_FILL: if (last) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end
                ST_STREAM: begin
                    used_q <= used_q + LEN_W'(1);
                    if (last || (used_q + LEN_W'(1) == len_q)) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/text_cell_engine_chk.sv
// Port-level protocol checks for text_cell_engine, bound to every instance.
module text_cell_engine_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              idx_pop,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r1_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);
    a_r2_even_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !mem_addr[0]);
    a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr && !mem_rd));
    a_r6_pop_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        idx_pop |-> (mem_wr && !mem_rd));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind text_cell_engine text_cell_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .idx_pop(idx_pop), .mem_addr(mem_addr)
);

// File: tb/test_text_cell_engine.sv
module test_text_cell_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, CW = 6, SW = 2, LW = 10, NW = 12;
    localparam int WORDS = 4096;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] opcode = '0;
    logic [AW-1:0] base_addr = '0;
    logic [SW-1:0] stride_exp = '0;
    logic [LW-1:0] line_pixels = 10'd160;
    logic [CW-1:0] src_col = '0, src_row = '0, dst_col = '0, dst_row = '0, rect_w = '0, rect_h = '0;
    logic [7:0] fill_glyph = '0, fg_color = '0, bg_color = '0, idx_data;
    logic [NW-1:0] stream_len = '0;
    logic idx_pop, busy, done, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    logic [15:0] mem [WORDS];
    logic [15:0] ref_mem [WORDS];
    logic [7:0] idx_buf [256];
    logic cnt_clr = 1'b0;
    int ptr, rd_cnt, wr_cnt, busy_cnt, done_cnt;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    text_cell_engine #(.ADDR_W(AW), .COORD_W(CW), .SHIFT_W(SW), .LINE_W(LW), .LEN_W(NW)) i_text_cell_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .base_addr(base_addr),
        .stride_exp(stride_exp), .line_pixels(line_pixels), .src_col(src_col), .src_row(src_row),
        .dst_col(dst_col), .dst_row(dst_row), .rect_w(rect_w), .rect_h(rect_h),
        .fill_glyph(fill_glyph), .fg_color(fg_color), .bg_color(bg_color), .stream_len(stream_len),
        .idx_data(idx_data), .idx_pop(idx_pop), .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] seed_word(int k);
        return 16'((k * 40503) ^ (k << 5) ^ 16'h5A5A);
    endfunction

    assign idx_data = idx_buf[ptr[7:0]];

    // memory model, stream source and activity counters
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) mem[k] <= seed_word(k);
        end else if (mem_wr) begin
            mem[mem_addr[12:1]] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[12:1]];
        if (cnt_clr) begin
            ptr <= 0; rd_cnt <= 0; wr_cnt <= 0; busy_cnt <= 0; done_cnt <= 0;
        end else begin
            if (idx_pop) ptr <= ptr + 1;
            if (mem_rd) rd_cnt <= rd_cnt + 1;
            if (mem_wr) wr_cnt <= wr_cnt + 1;
            if (busy) busy_cnt <= busy_cnt + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int widx(int c, int r);
        int s = 2 << stride_exp;
        return (int'(base_addr) + c * s + r * s * (int'(line_pixels) / 8)) >> 1;
    endfunction

    task automatic model_op();
        int w = int'(rect_w), h = int'(rect_h);
        logic [7:0] attr = {bg_color[3:0], fg_color[3:0]};
        if (w == 0 || h == 0) return;
        if (opcode == 2'd0) begin
            if (src_row > dst_row || (src_row == dst_row && src_col > dst_col)) begin
                for (int j = 0; j < h; j++) for (int i = 0; i < w; i++)
                    ref_mem[widx(dst_col + i, dst_row + j)] = ref_mem[widx(src_col + i, src_row + j)];
            end else begin
                for (int j = h - 1; j >= 0; j--) for (int i = w - 1; i >= 0; i--)
                    ref_mem[widx(dst_col + i, dst_row + j)] = ref_mem[widx(src_col + i, src_row + j)];
            end
        end else if (opcode == 2'd1) begin
            for (int j = 0; j < h; j++) for (int i = 0; i < w; i++)
                ref_mem[widx(dst_col + i, dst_row + j)] = {attr, fill_glyph};
        end else if (opcode == 2'd2) begin
            int n = 0;
            for (int j = 0; j < h; j++) for (int i = 0; i < w; i++)
                if (n < int'(stream_len)) begin
                    ref_mem[widx(dst_col + i, dst_row + j)] = {attr, idx_buf[n[7:0]]};
                    n++;
                end
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = -1;
        for (int k = 0; k < WORDS; k++) if (bad < 0 && mem[k] !== ref_mem[k]) bad = k;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, {req, " word mismatch"}, int'(mem[bad]), int'(ref_mem[bad]));
    endtask

    task automatic clear_counts();
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
    endtask

    // waits at negedges until done; returns cycles waited or -1 on timeout
    task automatic wait_done(output int cyc);
        cyc = -1;
        for (int t = 1; t <= 20000; t++) begin
            @(negedge clk);
            if (done) begin cyc = t; break; end
        end
        if (cyc < 0) chk(1'b0, "R8 watchdog", 0, 1);
    endtask

    task automatic set_op(input int op, input int sc, input int sr, input int dc, input int dr,
                          input int w, input int h, input int len);
        opcode = 2'(op); src_col = CW'(sc); src_row = CW'(sr); dst_col = CW'(dc); dst_row = CW'(dr);
        rect_w = CW'(w); rect_h = CW'(h); stream_len = NW'(len);
        fill_glyph = 8'($urandom); fg_color = 8'($urandom); bg_color = 8'($urandom);
    endtask

    // runs the staged op and checks memory, access counts and done pulse
    task automatic run_check(input string tag);
        int cyc, cells, exp_busy, exp_rd;
        cells = int'(rect_w) * int'(rect_h);
        if (opcode == 2'd3 || (opcode == 2'd2 && stream_len == '0)) cells = 0;
        if (opcode == 2'd2 && int'(stream_len) < cells) cells = int'(stream_len);
        exp_busy = (opcode == 2'd0) ? 2 * cells : cells;
        exp_rd = (opcode == 2'd0) ? cells : 0;
        model_op();
        clear_counts();
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (done) cyc = 1; else wait_done(cyc);
        @(negedge clk);
        cmp_mem({tag, " memory"});
        chk(busy_cnt == exp_busy, {tag, " R5 busy cycles"}, busy_cnt, exp_busy);
        chk(wr_cnt == cells && rd_cnt == exp_rd, {tag, " R5 access count"}, wr_cnt + rd_cnt, cells + exp_rd);
        chk(done_cnt == 1 && !done, {tag, " R8 single done"}, done_cnt, 1);
        if (opcode == 2'd2) chk(ptr == cells, {tag, " R6 pops"}, ptr, cells);
        if (cells == 0) chk(cyc == 1, {tag, " R7 immediate done"}, cyc, 1);
    endtask

    initial begin : main
        int cyc;
        void'($urandom(32'd1234));
        for (int k = 0; k < 256; k++) idx_buf[k] = 8'($urandom);
        for (int k = 0; k < WORDS; k++) ref_mem[k] = seed_word(k);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_rd && !mem_wr && !idx_pop, "R1 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        base_addr = 16'd64; stride_exp = 2'd0; line_pixels = 10'd160;

        set_op(1, 0, 0, 2, 1, 5, 3, 0);  run_check("R3 R2 fill");
        stride_exp = 2'd2;
        set_op(1, 0, 0, 1, 2, 3, 2, 0);  run_check("R3 R2 fill wide stride");
        stride_exp = 2'd1;
        set_op(0, 2, 4, 3, 2, 6, 4, 0);  run_check("R4 overlap src below");
        set_op(0, 3, 2, 2, 4, 6, 4, 0);  run_check("R4 overlap src above");
        set_op(0, 1, 3, 4, 3, 8, 2, 0);  run_check("R4 same row src left");
        set_op(0, 5, 3, 2, 3, 8, 2, 0);  run_check("R4 same row src right");
        set_op(2, 0, 0, 1, 1, 4, 3, 7);  run_check("R6 stream short");
        set_op(2, 0, 0, 2, 5, 3, 2, 40); run_check("R6 stream long");
        set_op(1, 0, 0, 1, 1, 0, 3, 0);  run_check("R7 zero width");
        set_op(0, 0, 0, 1, 1, 4, 0, 0);  run_check("R7 zero height");
        set_op(2, 0, 0, 1, 1, 4, 4, 0);  run_check("R7 zero length");
        set_op(3, 0, 0, 1, 1, 4, 4, 0);  run_check("R10 no-op opcode");

        // R9 start while busy is ignored
        set_op(1, 0, 0, 0, 0, 10, 6, 0);
        model_op();
        clear_counts();
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy, "R9 busy mid fill", int'(busy), 1);
        opcode = 2'd0; src_row = 6'd8; rect_w = 6'd3; start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(cyc);
        @(negedge clk);
        cmp_mem("R9 memory shows fill only");
        chk(done_cnt == 1 && busy_cnt == 60, "R9 one op only", busy_cnt, 60);

        // R9 start in the done cycle is accepted
        set_op(1, 0, 0, 3, 8, 4, 2, 0);
        model_op();
        clear_counts();
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(cyc);
        set_op(0, 3, 8, 4, 9, 4, 2, 0);
        model_op();
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy, "R9 accepted at done", int'(busy), 1);
        wait_done(cyc);
        @(negedge clk);
        cmp_mem("R9 chained memory");
        chk(done_cnt == 2, "R8 two done pulses", done_cnt, 2);

        // random mix
        for (int n = 0; n < 40; n++) begin
            int sc, dc, m;
            stride_exp = 2'($urandom_range(0, 2));
            base_addr = 16'(2 * $urandom_range(0, 100));
            sc = $urandom_range(0, 11); dc = $urandom_range(0, 11);
            m = (sc > dc) ? sc : dc;
            set_op($urandom_range(0, 2), sc, $urandom_range(0, 9), dc, $urandom_range(0, 9),
                   $urandom_range(0, 19 - m), $urandom_range(0, 5), $urandom_range(0, 30));
            run_check("R2 R3 R4 R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL R8 global watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule